// File: doc/BRIEF.md
# Row-Cached DRAM Control Decoder

This block is the device-side control logic of a DRAM that keeps one row in an SRAM read cache. A falling edge on the active-low row strobe starts an operation. At that edge the block samples the refresh, write/read and chip-select inputs and decodes them as a read, a write or a refresh. A read that misses copies the whole selected row into the cache register and records the row in a last-read-row latch. A read that hits that latch opens no array row. After a read, data comes out by column address alone, with no further row strobes, and the output enable gates it onto the outputs.

A transparent column latch supplies the column address. A write is triggered when the column latch input and write enable are both low. Refreshes take their row from an internal counter. The same refresh path serves a combined refresh/column-latch line that is held low before the strobe, which gives a column-before-row refresh. The array is a small register model: only the low bits of the row and column index it. Any row strobe other than a refresh while the device is deselected is flagged as illegal.

Top module: `cdram_ctrl_top`

## Requirements
- R1: At a falling edge of `rowStrobeN` with `refreshN` low, the block refreshes the row held in the internal refresh counter and ignores `addrIn`. On the next cycle `arrayAct` is 1 for one cycle and `actRow` equals that counter value. This holds whether `chipSelN` is high or low, and `illegalOp` stays 0.
- R2: At a falling edge of `rowStrobeN` with `refreshN` high and `chipSelN` low, the block captures the row from `addrIn[10:0]`. `writeReadSel`=1 starts a write cycle and `writeReadSel`=0 starts a read cycle.
- R3: The refresh counter resets to 0, increments by one after each refresh, and wraps from 2047 to 0.
- R4: While `colLatchN` is 1 the column address follows `addrIn[8:0]`. While `colLatchN` is 0 it holds the value present at the last clock edge at which `colLatchN` was 1.
- R5: During a write cycle, each cycle in which `colLatchN` and `writeEnN` become both low stores `dataIn` at the open row and the latched column. Several writes per strobe are allowed.
- R6: A read whose 11-bit row equals the last-read-row latch raises `cacheHit` for one cycle. It leaves `arrayAct` at 0 and does not reload the cache.
- R7: A falling edge of `rowStrobeN` with `refreshN` high and `chipSelN` high raises `illegalOp` for exactly one cycle. It performs no array access and opens no write cycle, so later write triggers store nothing.
- R8: `dataOut` shows the cache entry at the current column address whenever `outEnN` and `chipSelN` are both 0, with `dataValid` equal to 1. Otherwise `dataOut` is 0 and `dataValid` is 0.
- R9: If `refreshN` and `colLatchN` are held low together before the strobe falls (a column-before-row refresh), the block performs the counter refresh of R1 and needs no row address.
- R10: A read miss raises `arrayAct` with `actRow` equal to the row, loads the array row into the cache and updates the last-read-row latch. A write to the cached row also updates the cache copy, so it is readable on the cycle after the trigger. The model indexes the array by row bits [1:0] and column bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rowStrobeN | input | 1 | Row strobe, active low; falling edge starts an operation |
| refreshN | input | 1 | Refresh request, active low, sampled at strobe fall |
| writeReadSel | input | 1 | 1 = write, 0 = read, sampled at strobe fall |
| chipSelN | input | 1 | Chip select, active low |
| colLatchN | input | 1 | Column latch control; high = transparent |
| writeEnN | input | 1 | Write enable, active low |
| outEnN | input | 1 | Output enable, active low |
| addrIn | input | 11 | Multiplexed row/column address |
| dataIn | input | 4 | Write data |
| dataOut | output | 4 | Read data from the cache row |
| dataValid | output | 1 | High while dataOut is driven |
| cacheHit | output | 1 | One-cycle pulse on a read that hits the cached row |
| arrayAct | output | 1 | One-cycle pulse when an array row is opened |
| actRow | output | 11 | Row opened by the last array access |
| illegalOp | output | 1 | One-cycle pulse on a strobe while deselected |

## Verification
The pulses `arrayAct`, `cacheHit` and `illegalOp` and the value of `actRow` come from registers that update at the edge where the strobe fall is first seen. The bench lowers the strobe at a falling clock edge and samples these outputs at the next falling edge, then checks at the following one that the pulses have cleared. `dataOut` is combinational from the cache and the column latch, so column and output-enable sweeps are sampled one nanosecond after the inputs change. A write trigger lands in the cache at the clock edge where both controls are first seen low, so the bench reads the word back one full cycle later.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
  // Strobes from the control section to the datapath
  typedef struct packed {
    logic fillCache;   // copy selected array row into the cache
    logic writeArray;  // store dataIn at open row / latched column
    logic writeCache;  // mirror that store into the cache copy
  } dpStrobe_t;
endpackage

// File: rtl/cdram_ctrl.sv
module cdram_ctrl
  import cdram_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rowStrobeN,
  input  logic             refreshN,
  input  logic             writeReadSel,
  input  logic             chipSelN,
  input  logic             colLatchN,
  input  logic             writeEnN,
  input  logic [ROW_W-1:0] rowAddr,
  output dpStrobe_t        strobes,
  output logic [ROW_W-1:0] openRow,
  output logic             arrayAct,
  output logic [ROW_W-1:0] actRow,
  output logic             cacheHit,
  output logic             illegalOp
);
  logic             prevRs;
  logic             writeOpen;
  logic             prevBoth;
  logic             lrrValid;
  logic [ROW_W-1:0] lrrRow;
  logic [ROW_W-1:0] refCnt;

  logic rsFall, isRefresh, isIllegal, isWrite, isRead, readHit;
  logic bothLow, wrTrig;

  always_comb begin
    rsFall    = prevRs & ~rowStrobeN;
    isRefresh = rsFall & ~refreshN;
    isIllegal = rsFall & refreshN & chipSelN;
    isWrite   = rsFall & refreshN & ~chipSelN & writeReadSel;
    isRead    = rsFall & refreshN & ~chipSelN & ~writeReadSel;
    readHit   = isRead & lrrValid & (rowAddr == lrrRow);
    bothLow   = ~colLatchN & ~writeEnN;
    wrTrig    = writeOpen & bothLow & ~prevBoth;
    strobes.fillCache  = isRead & ~readHit;
    strobes.writeArray = wrTrig;
    strobes.writeCache = wrTrig & lrrValid & (openRow == lrrRow);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevRs    <= 1'b1;
      writeOpen <= 1'b0;
      prevBoth  <= 1'b0;
      lrrValid  <= 1'b0;
      lrrRow    <= '0;
      refCnt    <= '0;
      openRow   <= '0;
      arrayAct  <= 1'b0;
      actRow    <= '0;
      cacheHit  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      prevRs <= rowStrobeN;
      if (isWrite)         writeOpen <= 1'b1;
      else if (rowStrobeN) writeOpen <= 1'b0;
      prevBoth <= isWrite ? 1'b0 : bothLow;
      if (isWrite || isRead) openRow <= rowAddr;
      if (isRefresh) refCnt <= refCnt + ROW_W'(1);
      if (strobes.fillCache) begin
        lrrValid <= 1'b1;
        lrrRow   <= rowAddr;
      end
      arrayAct <= isRefresh | isWrite | strobes.fillCache;
      if (isRefresh)
        actRow <= refCnt;
      else if (isWrite || strobes.fillCache)
        actRow <= rowAddr;
      cacheHit  <= readHit;
      illegalOp <= isIllegal;
    end
  end
endmodule

// File: rtl/cdram_datapath.sv
module cdram_datapath
  import cdram_pkg::*;
#(
  parameter int DATA_W       = 4,
  parameter int ARR_ROW_BITS = 2,
  parameter int ARR_COL_BITS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  dpStrobe_t               strobes,
  input  logic [ARR_ROW_BITS-1:0] fillRow,
  input  logic [ARR_ROW_BITS-1:0] writeRow,
  input  logic [ARR_COL_BITS-1:0] colIn,
  input  logic                    colLatchN,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic                    outEnN,
  input  logic                    chipSelN,
  output logic [DATA_W-1:0]       dataOut,
  output logic                    dataValid
);
  localparam int ARR_ROWS = 1 << ARR_ROW_BITS;
  localparam int ARR_COLS = 1 << ARR_COL_BITS;

  logic [ARR_COL_BITS-1:0] colHeld;
  logic [ARR_COL_BITS-1:0] colAddr;
  logic [DATA_W-1:0]       mem   [ARR_ROWS][ARR_COLS];
  logic [DATA_W-1:0]       cache [ARR_COLS];

  // Transparent column latch: follows input while control high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         colHeld <= '0;
    else if (colLatchN) colHeld <= colIn;
  end
  assign colAddr = colLatchN ? colIn : colHeld;

  // Array rows, one generated block per modelled row
  for (genvar r = 0; r < ARR_ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int c = 0; c < ARR_COLS; c++) mem[r][c] <= '0;
      end else if (strobes.writeArray && writeRow == ARR_ROW_BITS'(r)) begin
        mem[r][colAddr] <= dataIn;
      end
    end
  end

  // Cache row register, one generated block per column
  for (genvar c = 0; c < ARR_COLS; c++) begin : g_cache
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cache[c] <= '0;
      else if (strobes.fillCache)
        cache[c] <= mem[fillRow][c];
      else if (strobes.writeCache && colAddr == ARR_COL_BITS'(c))
        cache[c] <= dataIn;
    end
  end

  always_comb begin
    dataValid = ~outEnN & ~chipSelN;
    dataOut   = dataValid ? cache[colAddr] : '0;
  end
endmodule

// File: rtl/cdram_ctrl_top.sv
module cdram_ctrl_top
  import cdram_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 4,
  parameter int ARR_ROW_BITS = 2,
  parameter int ARR_COL_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rowStrobeN,
  input  logic              refreshN,
  input  logic              writeReadSel,
  input  logic              chipSelN,
  input  logic              colLatchN,
  input  logic              writeEnN,
  input  logic              outEnN,
  input  logic [ROW_W-1:0]  addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              cacheHit,
  output logic              arrayAct,
  output logic [ROW_W-1:0]  actRow,
  output logic              illegalOp
);
  localparam int COL_USED = (ARR_COL_BITS < COL_W) ? ARR_COL_BITS : COL_W;

  dpStrobe_t        strobes;
  logic [ROW_W-1:0] openRow;

  cdram_ctrl #(.ROW_W(ROW_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rowStrobeN(rowStrobeN), .refreshN(refreshN),
    .writeReadSel(writeReadSel), .chipSelN(chipSelN), .colLatchN(colLatchN),
    .writeEnN(writeEnN), .rowAddr(addrIn), .strobes(strobes), .openRow(openRow),
    .arrayAct(arrayAct), .actRow(actRow), .cacheHit(cacheHit), .illegalOp(illegalOp)
  );

  cdram_datapath #(
    .DATA_W(DATA_W), .ARR_ROW_BITS(ARR_ROW_BITS), .ARR_COL_BITS(COL_USED)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .fillRow(addrIn[ARR_ROW_BITS-1:0]), .writeRow(openRow[ARR_ROW_BITS-1:0]),
    .colIn(addrIn[COL_USED-1:0]), .colLatchN(colLatchN), .dataIn(dataIn),
    .outEnN(outEnN), .chipSelN(chipSelN), .dataOut(dataOut), .dataValid(dataValid)
  );
endmodule

// File: rtl/cdram_chk.sv
module cdram_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rowStrobeN,
  input logic              refreshN,
  input logic              writeReadSel,
  input logic              chipSelN,
  input logic              outEnN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataValid,
  input logic              cacheHit,
  input logic              arrayAct,
  input logic              illegalOp
);
  p_refresh_act_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rowStrobeN) && !refreshN |=> arrayAct && !illegalOp);

  p_write_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rowStrobeN) && refreshN && !chipSelN && writeReadSel |=> arrayAct && !cacheHit);

  p_hit_no_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cacheHit |-> !arrayAct);

  p_illegal_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rowStrobeN) && refreshN && chipSelN |=> illegalOp && !arrayAct);

  p_illegal_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegalOp |=> !illegalOp);

  p_out_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outEnN |-> (dataOut == '0) && !dataValid);
endmodule

bind cdram_ctrl_top cdram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rowStrobeN(rowStrobeN), .refreshN(refreshN),
  .writeReadSel(writeReadSel), .chipSelN(chipSelN), .outEnN(outEnN),
  .dataOut(dataOut), .dataValid(dataValid), .cacheHit(cacheHit),
  .arrayAct(arrayAct), .illegalOp(illegalOp)
);

// File: tb/cdram_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module cdram_ctrl_top_tb_top;
  localparam int ROW_W = 11, DATA_W = 4, NROW = 4, NCOL = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rowStrobeN = 1, refreshN = 1, writeReadSel = 0, chipSelN = 0;
  logic colLatchN = 1, writeEnN = 1, outEnN = 1;
  logic [ROW_W-1:0]  addrIn = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic dataValid, cacheHit, arrayAct, illegalOp;
  logic [ROW_W-1:0]  actRow;

  int errors = 0, checks = 0;

  // Bench model
  logic [DATA_W-1:0] mMem [NROW][NCOL];
  logic [DATA_W-1:0] mCache [NCOL];
  logic [ROW_W-1:0]  mLrr = '0;
  bit                mLrrValid = 0;
  logic [ROW_W-1:0]  mRef = '0;

  always #2 clk = ~clk;

  cdram_ctrl_top dut_i (.*);

  function automatic logic [DATA_W-1:0] pat(int r, int c, int salt);
    return DATA_W'((r * 5 + c * 3 + 1 + salt) & 15);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  // Strobe cycle: ref/write/read/illegal decoded, outputs sampled next negedge
  task automatic rsCycle(bit refN, bit wr, bit csN, logic [ROW_W-1:0] row, bit keepLow);
    bit expAct, expHit, expIll;
    logic [ROW_W-1:0] expRow;
    expAct = 0; expHit = 0; expIll = 0; expRow = actRow;
    @(negedge clk);
    refreshN = refN; writeReadSel = wr; chipSelN = csN; addrIn = row; rowStrobeN = 0;
    if (!refN) begin
      expAct = 1; expRow = mRef; mRef = mRef + 1'b1;
    end else if (csN) begin
      expIll = 1;
    end else if (wr) begin
      expAct = 1; expRow = row;
    end else if (mLrrValid && row == mLrr) begin
      expHit = 1;
    end else begin
      expAct = 1; expRow = row; mLrr = row; mLrrValid = 1;
      for (int c = 0; c < NCOL; c++) mCache[c] = mMem[row % NROW][c];
    end
    @(negedge clk);
    check("R1/R2/R10 arrayAct", arrayAct, expAct);
    if (expAct) check("R1/R3/R10 actRow", actRow, expRow);
    check("R6 cacheHit", cacheHit, expHit);
    check("R7 illegalOp", illegalOp, expIll);
    refreshN = 1;
    if (!keepLow) begin
      rowStrobeN = 1;
      @(negedge clk);
      check("R7 illegalOp one cycle", illegalOp, 0);
    end
  endtask

  // Write trigger on column col with data d (row strobe already low)
  task automatic wrTrig(int col, logic [DATA_W-1:0] d, logic [ROW_W-1:0] row, bit real_);
    @(negedge clk);
    colLatchN = 1; writeEnN = 1; addrIn = ROW_W'(col); dataIn = d;
    @(negedge clk);
    colLatchN = 0; writeEnN = 0;
    @(negedge clk);
    colLatchN = 1; writeEnN = 1;
    if (real_) begin
      mMem[row % NROW][col] = d;
      if (mLrrValid && row == mLrr) mCache[col] = d;
    end
  endtask

  task automatic endStrobe();
    @(negedge clk); rowStrobeN = 1;
    @(negedge clk);
  endtask

  task automatic readCol(int col, string req);
    colLatchN = 1; chipSelN = 0; outEnN = 0; addrIn = ROW_W'(col);
    #1;
    check(req, dataOut, mCache[col]);
    check("R8 dataValid", dataValid, 1);
  endtask

  initial begin
    for (int r = 0; r < NROW; r++) for (int c = 0; c < NCOL; c++) mMem[r][c] = '0;
    for (int c = 0; c < NCOL; c++) mCache[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    check("R3 reset arrayAct", arrayAct, 0);
    check("R7 reset illegalOp", illegalOp, 0);
    check("R6 reset cacheHit", cacheHit, 0);
    check("R8 reset dataOut gated", dataOut, 0);

    // R2/R5: page-mode writes filling every modelled row
    for (int r = 0; r < NROW; r++) begin
      rsCycle(1, 1, 0, ROW_W'(r), 1);
      for (int c = 0; c < NCOL; c++) wrTrig(c, pat(r, c, 0), ROW_W'(r), 1);
      endStrobe();
    end

    // R10/R8: read misses, sweep columns, output enable gating
    for (int r = 0; r < NROW; r++) begin
      rsCycle(1, 0, 0, ROW_W'(r), 0);
      for (int c = 0; c < NCOL; c++) readCol(c, "R5/R8/R10 read data");
      outEnN = 1; #1;
      check("R8 outEnN high gates data", dataOut, 0);
      check("R8 outEnN high dataValid", dataValid, 0);
      outEnN = 0; chipSelN = 1; #1;
      check("R8 chipSelN high gates data", dataOut, 0);
      chipSelN = 0;
    end

    // R6: read of cached row hits, aliasing row misses
    rsCycle(1, 0, 0, ROW_W'(3), 0);
    rsCycle(1, 0, 0, ROW_W'(3 + 4 * 100), 0);   // same array row, different row: miss
    rsCycle(1, 0, 0, ROW_W'(3 + 4 * 100), 0);   // now a hit
    for (int c = 0; c < NCOL; c++) readCol(c, "R6 data after hit");

    // R10: write to cached row updates cache copy
    rsCycle(1, 1, 0, ROW_W'(3 + 4 * 100), 1);
    wrTrig(5, 4'hA, ROW_W'(3 + 4 * 100), 1);
    wrTrig(2, 4'h6, ROW_W'(3 + 4 * 100), 1);
    endStrobe();
    readCol(5, "R10 cache mirrors write");
    readCol(2, "R10 cache mirrors write 2");

    // R4: transparent latch and hold
    @(negedge clk);
    colLatchN = 1; outEnN = 0; addrIn = 11'd1;
    @(negedge clk);
    colLatchN = 0; addrIn = 11'd6; #1;
    check("R4 held column", dataOut, mCache[1]);
    colLatchN = 1; #1;
    check("R4 transparent column", dataOut, mCache[6]);

    // R7: deselected read/write flagged, write trigger stores nothing
    rsCycle(1, 0, 1, ROW_W'(0), 0);
    rsCycle(1, 1, 1, ROW_W'(3 + 4 * 100), 1);
    wrTrig(5, 4'h1, ROW_W'(3 + 4 * 100), 0);
    endStrobe();
    readCol(5, "R7 no write while deselected");
    // R1: deselected refresh is legal
    rsCycle(0, 0, 1, ROW_W'(0), 0);
    chipSelN = 0;

    // R9: combined refresh/column line low before the strobe
    @(negedge clk);
    refreshN = 0; colLatchN = 0; addrIn = 11'h555;
    @(negedge clk);
    rsCycle(0, 0, 0, 11'h2AA, 0);
    colLatchN = 1;

    // R1/R3: refresh sweep through counter wrap, address pins scrambled
    for (int i = 0; i < 2052; i++)
      rsCycle(0, i[0], 0, ROW_W'(i * 37), 0);
    check("R3 counter wrapped", 32'(mRef), 32'(ROW_W'(2052 + 2)));

    // After refreshes, cached row still hits
    rsCycle(1, 0, 0, ROW_W'(3 + 4 * 100), 0);

    finishRun();
  end
endmodule